// File: doc/BRIEF.md
# Watchdog Input Conditioning Unit

This block sits in front of a window-watchdog state machine and turns three raw, asynchronous control pins into clean, clock-aligned signals. The trigger input from the supervised processor, the mode input that selects between short and long monitoring windows, and the wake-up input each pass through a synchroniser and then a debounce filter. Each filter has its own length. The trigger and mode filters are short. The wake-up filter is much longer, so contact bounce and noise on a slow external line are rejected.

On top of the filtered levels, the block generates the single-cycle events the state machine consumes. One strobe marks each accepted rising edge of the trigger. A second strobe flags a trigger that has been held low for longer than a set limit. A third marks every accepted change of the wake-up line, in either direction. Each input comes out of reset at the level its external pull resistor would give: trigger and mode high, wake-up low.

Top module: `wdin_cond`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `trig_lvl` and `mode_lvl` are 1 and `trig_ok`, `trig_err` and `wake_edge` are 0.
- R2: A change on `trig_raw` or `mode_raw` that holds steadily appears on `trig_lvl` or `mode_lvl` exactly SYNC_STAGES + LEN rising clock edges after it is applied. With the defaults this is 6 edges. Two changes of one filtered level are at least LEN cycles apart.
- R3: A change on `trig_raw` or `mode_raw` that lasts fewer than LEN cycles leaves the filtered level unchanged and raises no strobe.
- R4: `trig_ok` is high for exactly one cycle, in the same cycle in which `trig_lvl` goes from 0 to 1. It is never high at any other time.
- R5: `trig_err` pulses in the cycle after `trig_lvl` has been 0 for TRIG_LOW_MAX consecutive cycles, which is the 46th low cycle with the default of 45. A low phase of exactly TRIG_LOW_MAX cycles produces no pulse. The pulse is only ever given while `trig_lvl` is 0.
- R6: `trig_err` pulses at most once per low phase of `trig_lvl`, however long that phase lasts. It is re-armed when `trig_lvl` returns to 1.
- R7: `wake_edge` is high for exactly one cycle for each accepted change of `wake_raw`, rising or falling. The pulse comes SYNC_STAGES + WAKE_LEN edges after the change, which is 130 with the defaults.
- R8: A change of `wake_raw` that lasts WAKE_LEN − 1 cycles produces no `wake_edge`. A change that lasts exactly WAKE_LEN cycles produces one pulse for the change and one for the return.
- R9: Any cycle in which the synchronised input agrees with the filtered level restarts that filter's count. A raw input that bounces back for one cycle is therefore accepted only LEN + SYNC_STAGES edges after its last change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_raw | input | 1 | Asynchronous trigger pin, idles high |
| mode_raw | input | 1 | Asynchronous window-select pin, idles high |
| wake_raw | input | 1 | Asynchronous wake-up pin, idles low |
| trig_lvl | output | 1 | Filtered trigger level |
| mode_lvl | output | 1 | Filtered mode level |
| trig_ok | output | 1 | One-cycle strobe on an accepted trigger rise |
| trig_err | output | 1 | One-cycle strobe when the trigger stays low too long |
| wake_edge | output | 1 | One-cycle strobe on any accepted wake-up change |

## Verification
The properties take it for granted that each filter length is at least two cycles. Under that assumption a filtered level cannot change on two edges in a row, and a strobe can never last two cycles. They also take for granted that reset is held from time zero, so that every register starts from its idle value. The stimulus only applies raw changes on the falling clock edge and keeps the default lengths. Each new raw change is applied only after the previous scenario's output has settled, so every expected event falls on a known edge count from the change that caused it.

// File: rtl/wdin_pkg.sv
`timescale 1ns/1ps
package wdin_pkg;

  // Which one-cycle event a conditioning channel reports on its strobe.
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_sel_e;

  // Bits needed to hold a count from 0 up to n inclusive.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/wdin_sync.sv
`timescale 1ns/1ps
module wdin_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  // Stage 0 samples the pin; each further stage samples the one before it.
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= IDLE;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= IDLE;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/wdin_chan.sv
`timescale 1ns/1ps
module wdin_chan
  import wdin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEN         = 4,
  parameter bit          IDLE        = 1'b1,
  parameter edge_sel_e   EDGES       = EDGE_NONE
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl,
  output logic strobe,
  output logic rise_now
);

  localparam int unsigned CW = cnt_bits(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic          synced;
  logic [CW-1:0] run_cnt;
  logic          lvl_q;
  logic          differ;
  logic          accept;

  wdin_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw),
    .dout (synced)
  );

  assign differ   = (synced != lvl_q);
  assign accept   = differ && (run_cnt == LAST);
  assign rise_now = accept && synced;

  // Counts consecutive cycles of disagreement; any agreeing cycle restarts it.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lvl_q   <= IDLE;
    end else begin
      if (!differ || accept) run_cnt <= '0;
      else                   run_cnt <= run_cnt + 1'b1;
      if (accept) lvl_q <= synced;
    end
  end

  assign lvl = lvl_q;

  if (EDGES == EDGE_RISE) begin : g_rise
    always_ff @(posedge clk) begin
      if (rst) strobe <= 1'b0;
      else     strobe <= accept && synced;
    end
  end else if (EDGES == EDGE_ANY) begin : g_any
    always_ff @(posedge clk) begin
      if (rst) strobe <= 1'b0;
      else     strobe <= accept;
    end
  end else begin : g_none
    assign strobe = 1'b0;
  end

endmodule

// File: rtl/wdin_lowcheck.sv
`timescale 1ns/1ps
module wdin_lowcheck
  import wdin_pkg::*;
#(
  parameter int unsigned LIMIT = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic rise_now,
  output logic err
);

  localparam int unsigned CW = cnt_bits(LIMIT);
  localparam logic [CW-1:0] CAP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] low_cnt;
  logic          err_q;

  // low_cnt saturates at LIMIT so the error fires once per low phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= !lvl && !rise_now && (low_cnt == LAST);
      if (lvl)                 low_cnt <= '0;
      else if (low_cnt != CAP) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/wdin_cond.sv
`timescale 1ns/1ps
module wdin_cond
  import wdin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned TRIG_LEN     = 4,
  parameter int unsigned MODE_LEN     = 4,
  parameter int unsigned WAKE_LEN     = 128,
  parameter int unsigned TRIG_LOW_MAX = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_raw,
  input  logic mode_raw,
  input  logic wake_raw,
  output logic trig_lvl,
  output logic mode_lvl,
  output logic trig_ok,
  output logic trig_err,
  output logic wake_edge
);

  logic trig_rise_now;
  logic mode_strobe_unused;
  logic mode_rise_unused;
  logic wake_lvl_unused;
  logic wake_rise_unused;

  wdin_chan #(
    .SYNC_STAGES (SYNC_STAGES),
    .LEN         (TRIG_LEN),
    .IDLE        (1'b1),
    .EDGES       (EDGE_RISE)
  ) u_trig (
    .clk      (clk),
    .rst      (rst),
    .raw      (trig_raw),
    .lvl      (trig_lvl),
    .strobe   (trig_ok),
    .rise_now (trig_rise_now)
  );

  wdin_chan #(
    .SYNC_STAGES (SYNC_STAGES),
    .LEN         (MODE_LEN),
    .IDLE        (1'b1),
    .EDGES       (EDGE_NONE)
  ) u_mode (
    .clk      (clk),
    .rst      (rst),
    .raw      (mode_raw),
    .lvl      (mode_lvl),
    .strobe   (mode_strobe_unused),
    .rise_now (mode_rise_unused)
  );

  wdin_chan #(
    .SYNC_STAGES (SYNC_STAGES),
    .LEN         (WAKE_LEN),
    .IDLE        (1'b0),
    .EDGES       (EDGE_ANY)
  ) u_wake (
    .clk      (clk),
    .rst      (rst),
    .raw      (wake_raw),
    .lvl      (wake_lvl_unused),
    .strobe   (wake_edge),
    .rise_now (wake_rise_unused)
  );

  wdin_lowcheck #(.LIMIT(TRIG_LOW_MAX)) u_low (
    .clk      (clk),
    .rst      (rst),
    .lvl      (trig_lvl),
    .rise_now (trig_rise_now),
    .err      (trig_err)
  );

endmodule

// File: rtl/wdin_cond_chk.sv
`timescale 1ns/1ps
module wdin_cond_chk (
  input logic clk,
  input logic rst,
  input logic trig_lvl,
  input logic mode_lvl,
  input logic trig_ok,
  input logic trig_err,
  input logic wake_edge
);

  // R1: first cycle out of reset shows the idle pattern
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (trig_lvl && mode_lvl && !trig_ok && !trig_err && !wake_edge));

  // R2: filtered mode level cannot change on two edges in a row
  a_r2_mode_settles: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_lvl) |=> $stable(mode_lvl));

  // R4: ok strobe lasts one cycle
  a_r4_ok_one_cycle: assert property (@(posedge clk) disable iff (rst)
    trig_ok |=> !trig_ok);

  // R4: ok strobe only with a fresh rise of the level
  a_r4_ok_on_rise: assert property (@(posedge clk) disable iff (rst)
    trig_ok |-> (trig_lvl && !$past(trig_lvl)));

  // R4: every rise of the level carries the strobe
  a_r4_rise_has_ok: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_lvl) |-> trig_ok);

  // R5: error only while the trigger is low
  a_r5_err_while_low: assert property (@(posedge clk) disable iff (rst)
    trig_err |-> !trig_lvl);

  // R6: error strobe lasts one cycle
  a_r6_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    trig_err |=> !trig_err);

  // R7: wake strobe lasts one cycle
  a_r7_wake_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_edge |=> !wake_edge);

endmodule

bind wdin_cond wdin_cond_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_lvl  (trig_lvl),
  .mode_lvl  (mode_lvl),
  .trig_ok   (trig_ok),
  .trig_err  (trig_err),
  .wake_edge (wake_edge)
);

// File: tb/wdin_cond_test.sv
`timescale 1ns/1ps
module wdin_cond_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_raw = 1'b1;
  logic mode_raw = 1'b1;
  logic wake_raw = 1'b0;
  logic trig_lvl, mode_lvl, trig_ok, trig_err, wake_edge;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int ok_n, ok_at, err_n, err_at, wk_n, wk_at;
  bit trig_dropped, mode_dropped;

  always #10 clk = ~clk;

  wdin_cond uut (
    .clk       (clk),
    .rst       (rst),
    .trig_raw  (trig_raw),
    .mode_raw  (mode_raw),
    .wake_raw  (wake_raw),
    .trig_lvl  (trig_lvl),
    .mode_lvl  (mode_lvl),
    .trig_ok   (trig_ok),
    .trig_err  (trig_err),
    .wake_edge (wake_edge)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sample n falling edges, counting strobes. Release the trigger (sel 1) or
  // mode (sel 2) pin back to high right after the sample at index rel_at.
  task automatic watch(input int n, input int rel_at, input int sel);
    ok_n = 0; ok_at = -1; err_n = 0; err_at = -1; wk_n = 0; wk_at = -1;
    trig_dropped = 1'b0; mode_dropped = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (trig_ok)   begin ok_n++;  if (ok_at  < 0) ok_at  = k; end
      if (trig_err)  begin err_n++; if (err_at < 0) err_at = k; end
      if (wake_edge) begin wk_n++;  if (wk_at  < 0) wk_at  = k; end
      if (!trig_lvl) trig_dropped = 1'b1;
      if (!mode_lvl) mode_dropped = 1'b1;
      if (k == rel_at) begin
        if (sel == 1) trig_raw = 1'b1;
        if (sel == 2) mode_raw = 1'b1;
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(4);
    chk("R1", "trig_lvl in reset", int'(trig_lvl), 1);
    chk("R1", "mode_lvl in reset", int'(mode_lvl), 1);
    rst = 1'b0;
    step(1);
    chk("R1", "trig_lvl after reset", int'(trig_lvl), 1);
    chk("R1", "mode_lvl after reset", int'(mode_lvl), 1);
    chk("R1", "strobes after reset", int'({trig_ok, trig_err, wake_edge}), 0);
  endtask

  task automatic t_trig_cycle();
    trig_raw = 1'b0;
    step(5);
    chk("R2", "trig_lvl one edge early", int'(trig_lvl), 1);
    step(1);
    chk("R2", "trig_lvl at edge 6", int'(trig_lvl), 0);
    trig_raw = 1'b1;
    watch(12, -1, 0);
    chk("R4", "ok count", ok_n, 1);
    chk("R4", "ok edge", ok_at, 6);
    chk("R5", "no err on short low", err_n, 0);
  endtask

  task automatic t_mode();
    mode_raw = 1'b0;
    step(5);
    chk("R2", "mode_lvl one edge early", int'(mode_lvl), 1);
    step(1);
    chk("R2", "mode_lvl at edge 6", int'(mode_lvl), 0);
    mode_raw = 1'b1;
    step(5);
    chk("R2", "mode_lvl stays low", int'(mode_lvl), 0);
    step(1);
    chk("R2", "mode_lvl back high", int'(mode_lvl), 1);
    step(4);
  endtask

  task automatic t_glitch();
    trig_raw = 1'b0;
    watch(20, 3, 1);
    chk("R3", "trig glitch level", int'(trig_dropped), 0);
    chk("R3", "trig glitch ok", ok_n, 0);
    mode_raw = 1'b0;
    watch(20, 3, 2);
    chk("R3", "mode glitch level", int'(mode_dropped), 0);
  endtask

  task automatic t_restart();
    trig_raw = 1'b0;
    step(3);
    trig_raw = 1'b1;
    step(1);
    trig_raw = 1'b0;
    step(5);
    chk("R9", "level held after bounce", int'(trig_lvl), 1);
    step(1);
    chk("R9", "level after restarted count", int'(trig_lvl), 0);
    trig_raw = 1'b1;
    step(12);
  endtask

  task automatic t_low(input int n, input int exp_err, input string req);
    trig_raw = 1'b0;
    watch(n + 70, n, 1);
    chk(req, $sformatf("err count low %0d", n), err_n, exp_err);
    if (exp_err > 0) chk(req, "err edge", err_at, 51);
    chk("R4", $sformatf("ok edge after low %0d", n), ok_at, n + 6);
  endtask

  task automatic t_wake();
    wake_raw = 1'b1;
    watch(140, -1, 0);
    chk("R7", "wake rise count", wk_n, 1);
    chk("R7", "wake rise edge", wk_at, 130);
    wake_raw = 1'b0;
    watch(140, -1, 0);
    chk("R7", "wake fall count", wk_n, 1);
    chk("R7", "wake fall edge", wk_at, 130);
  endtask

  task automatic t_wake_glitch();
    wake_raw = 1'b1;
    step(127);
    wake_raw = 1'b0;
    watch(200, -1, 0);
    chk("R8", "wake 127-cycle pulse", wk_n, 0);
    wake_raw = 1'b1;
    step(128);
    wake_raw = 1'b0;
    watch(200, -1, 0);
    chk("R8", "wake 128-cycle pulse edges", wk_n, 2);
  endtask

  initial begin
    t_reset();
    t_trig_cycle();
    t_mode();
    t_glitch();
    t_restart();
    t_low(45, 0, "R5");
    t_low(46, 1, "R5");
    t_low(120, 1, "R6");
    t_wake();
    t_wake_glitch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule